// File: doc/BRIEF.md
# CPU and Video Shared-Bus Arbiter

This block decides, clock by clock, who owns a single memory bus that serves both a Z80-style processor and a bitmap video fetcher for a 256x192 display. The video side has the bus by default: the arbiter holds the processor's active-low bus-request line asserted and lets the video fetcher select memory only once the processor has acknowledged the release. The request is withdrawn, and the processor runs, during every horizontal sync, while the processor's I/O strobe is active, and during one extra window picked by a 2-bit mode input.

Video fetches are single-cycle slots. A slot that finds the bus granted is reported as served. A slot that finds it not granted is dropped at once and never waits. The fetch address is formed from a pixel row and byte column, with two 3-bit groups exchanged to match the interleaved framebuffer layout. A falling edge on the frame sync becomes a bounded active-low interrupt pulse, because the processor's interrupt input is level-sensitive.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is held, `cpu_busreq_n` and `cpu_int_n` are 1 and `vid_fetch_go`, `vid_fetch_drop` and `vid_addr` are 0. After reset, the mode-3 phase begins with the bus requested for video.
- R2: On a clock edge where `line_sync_n` is 0, `cpu_busreq_n` becomes 1 at that edge, whatever the mode.
- R3: With mode 2'b00 and no other release term active, `cpu_busreq_n` becomes 0 at the next edge. With mode 2'b01, `cpu_busreq_n` becomes 1 at the next edge.
- R4: With mode 2'b10, `cpu_busreq_n` follows `cpu_a14` one edge later: 1 when the sampled address bit was 0, and 0 otherwise (unless another release term is active).
- R5: With mode 2'b11, a free-running phase toggles every SPLIT_CYCLES clocks from reset. The bus is released while the phase is 1 and requested while it is 0.
- R6: On a clock edge where `cpu_iorq_n` is 0, `cpu_busreq_n` becomes 1 at that edge.
- R7: `vid_sel` is 1 exactly when both `cpu_busack_n` and `cpu_busreq_n` are 0.
- R8: A `vid_fetch` slot sampled with `vid_sel` at 1 gives `vid_fetch_go`=1 for one cycle at the next edge. A slot sampled with `vid_sel` at 0 gives `vid_fetch_drop`=1 instead. Both are 0 at any edge without a slot.
- R9: At a fetch slot, `vid_addr` is loaded from the linear offset L = {row, col} (col in bits 4:0, row above it), with L[7:5] placed at address bits 10:8, L[10:8] placed at address bits 7:5, and every other bit left in place.
- R10: A falling edge on `frame_sync_n` drives `cpu_int_n` to 0 from the next edge for exactly INT_CYCLES clocks. A level that stays low does not start a new pulse.
- R11: An edge that samples `cpu_m1_n` and `cpu_iorq_n` both at 0 (interrupt acknowledge) ends a running pulse at that edge, unless the same edge samples a new frame-sync fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Extra release window select |
| line_sync_n | input | 1 | Active-low horizontal sync |
| frame_sync_n | input | 1 | Active-low frame sync |
| cpu_a14 | input | 1 | Processor address bit 14 |
| cpu_iorq_n | input | 1 | Processor I/O request strobe, active low |
| cpu_m1_n | input | 1 | Processor opcode-fetch strobe, active low |
| cpu_busack_n | input | 1 | Processor bus acknowledge, active low |
| cpu_busreq_n | output | 1 | Bus request to the processor, active low |
| cpu_int_n | output | 1 | Maskable interrupt to the processor, active low |
| vid_row | input | 8 | Pixel row of the fetch |
| vid_col | input | 5 | Byte column of the fetch |
| vid_fetch | input | 1 | Fetch slot strobe |
| vid_sel | output | 1 | Video memory select, active high |
| vid_addr | output | 13 | Scrambled fetch address |
| vid_fetch_go | output | 1 | Slot was served |
| vid_fetch_drop | output | 1 | Slot was dropped |

## Verification
Each release term is driven on its own against a bus that would otherwise be requested: line-sync pulses, I/O strobes, address bit 14 toggling in mode 2'b10, and long mode-2'b11 runs. A wrong term or a wrong mode decode then shows as a request edge in the wrong cycle. Fetch slots run once with the stand-in processor acknowledging and once with it withholding acknowledge. This separates served slots from dropped ones. Row values with single bits set in each group show whether the two 3-bit groups are swapped in the right direction. The interrupt is tried with an untouched pulse, a pulse cut short by an acknowledge, and a frame sync held low. These show the pulse length, the early end and the absence of retriggering.

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 5,
  parameter int SPLIT_CYCLES = 8,
  parameter int INT_CYCLES   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     line_sync_n,
  input  logic                     frame_sync_n,
  input  logic                     cpu_a14,
  input  logic                     cpu_iorq_n,
  input  logic                     cpu_m1_n,
  input  logic                     cpu_busack_n,
  output logic                     cpu_busreq_n,
  output logic                     cpu_int_n,
  input  logic [ROW_W-1:0]         vid_row,
  input  logic [COL_W-1:0]         vid_col,
  input  logic                     vid_fetch,
  output logic                     vid_sel,
  output logic [ROW_W+COL_W-1:0]   vid_addr,
  output logic                     vid_fetch_go,
  output logic                     vid_fetch_drop
);
  localparam int AW  = ROW_W + COL_W;
  localparam int SW  = (SPLIT_CYCLES > 1) ? $clog2(SPLIT_CYCLES) : 1;
  localparam int IW  = $clog2(INT_CYCLES + 1);
  localparam logic [SW-1:0] SPLIT_LAST = SW'(SPLIT_CYCLES - 1);
  localparam logic [IW-1:0] INT_LOAD   = IW'(INT_CYCLES);

  logic [SW-1:0] split_cnt;
  logic          split_phase;
  logic          mode_rel, release_bus;
  logic          fs_prev, fs_fall, int_ack;
  logic [IW-1:0] int_cnt;
  logic [AW-1:0] lin, scr;

  always_comb begin
    case (mode)
      2'b01:   mode_rel = 1'b1;
      2'b10:   mode_rel = ~cpu_a14;
      2'b11:   mode_rel = split_phase;
      default: mode_rel = 1'b0;
    endcase
  end

  assign release_bus = ~line_sync_n | ~cpu_iorq_n | mode_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_cnt   <= '0;
      split_phase <= 1'b0;
    end else if (split_cnt == SPLIT_LAST) begin
      split_cnt   <= '0;
      split_phase <= ~split_phase;
    end else begin
      split_cnt   <= split_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_busreq_n <= 1'b1;
    else        cpu_busreq_n <= release_bus;
  end

  assign vid_sel = ~cpu_busack_n & ~cpu_busreq_n;

  assign lin = {vid_row, vid_col};
  always_comb begin
    scr        = lin;
    scr[10:8]  = lin[7:5];
    scr[7:5]   = lin[10:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_fetch_go   <= 1'b0;
      vid_fetch_drop <= 1'b0;
      vid_addr       <= '0;
    end else begin
      vid_fetch_go   <= vid_fetch & vid_sel;
      vid_fetch_drop <= vid_fetch & ~vid_sel;
      if (vid_fetch) vid_addr <= scr;
    end
  end

  assign fs_fall = fs_prev & ~frame_sync_n;
  assign int_ack = ~cpu_m1_n & ~cpu_iorq_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_prev <= 1'b1;
      int_cnt <= '0;
    end else begin
      fs_prev <= frame_sync_n;
      if (fs_fall)             int_cnt <= INT_LOAD;
      else if (int_ack)        int_cnt <= '0;
      else if (int_cnt != '0)  int_cnt <= int_cnt - 1'b1;
    end
  end

  assign cpu_int_n = (int_cnt == '0);
endmodule

// File: rtl/bus_arbiter_checks.sv
module bus_arbiter_checks #(
  parameter int INT_CYCLES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       line_sync_n,
  input logic       frame_sync_n,
  input logic       cpu_iorq_n,
  input logic       cpu_m1_n,
  input logic       cpu_busack_n,
  input logic       cpu_busreq_n,
  input logic       cpu_int_n,
  input logic       vid_fetch,
  input logic       vid_sel,
  input logic       vid_fetch_go,
  input logic       vid_fetch_drop
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || cpu_int_n) low_run <= '0;
    else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
  end

  p_line_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_sync_n |=> cpu_busreq_n);

  p_mode_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> cpu_busreq_n);

  p_iorq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_iorq_n |=> cpu_busreq_n);

  p_sel_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vid_sel |-> (!cpu_busack_n && !cpu_busreq_n));

  p_fetch_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_fetch_go && vid_fetch_drop));

  p_fetch_needs_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_fetch |=> (!vid_fetch_go && !vid_fetch_drop));

  p_int_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_sync_n) |=> !cpu_int_n);

  p_int_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(INT_CYCLES));

  p_int_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_m1_n && !cpu_iorq_n && !$fell(frame_sync_n)) |=> cpu_int_n);
endmodule

bind shared_bus_arbiter bus_arbiter_checks #(.INT_CYCLES(INT_CYCLES)) u_checks (
  .clk(clk), .rst_n(rst_n), .mode(mode), .line_sync_n(line_sync_n),
  .frame_sync_n(frame_sync_n), .cpu_iorq_n(cpu_iorq_n), .cpu_m1_n(cpu_m1_n),
  .cpu_busack_n(cpu_busack_n), .cpu_busreq_n(cpu_busreq_n), .cpu_int_n(cpu_int_n),
  .vid_fetch(vid_fetch), .vid_sel(vid_sel), .vid_fetch_go(vid_fetch_go),
  .vid_fetch_drop(vid_fetch_drop)
);

// File: tb/test_shared_bus_arbiter.sv
`timescale 1ns/1ps
module test_shared_bus_arbiter;
  localparam int SPLIT = 8;
  localparam int INTC  = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic line_sync_n = 1'b1, frame_sync_n = 1'b1, cpu_a14 = 1'b1;
  logic cpu_iorq_n = 1'b1, cpu_m1_n = 1'b1, cpu_busack_n = 1'b1;
  logic [7:0] vid_row = '0;
  logic [4:0] vid_col = '0;
  logic vid_fetch = 1'b0;
  logic cpu_busreq_n, cpu_int_n, vid_sel, vid_fetch_go, vid_fetch_drop;
  logic [12:0] vid_addr;
  logic ack_hold = 1'b0;

  shared_bus_arbiter #(.SPLIT_CYCLES(SPLIT), .INT_CYCLES(INTC)) i_shared_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_sync_n(line_sync_n),
    .frame_sync_n(frame_sync_n), .cpu_a14(cpu_a14), .cpu_iorq_n(cpu_iorq_n),
    .cpu_m1_n(cpu_m1_n), .cpu_busack_n(cpu_busack_n), .cpu_busreq_n(cpu_busreq_n),
    .cpu_int_n(cpu_int_n), .vid_row(vid_row), .vid_col(vid_col), .vid_fetch(vid_fetch),
    .vid_sel(vid_sel), .vid_addr(vid_addr), .vid_fetch_go(vid_fetch_go),
    .vid_fetch_drop(vid_fetch_drop));

  // stand-in processor: acknowledges one clock after the request
  always @(posedge clk) cpu_busack_n <= ack_hold ? 1'b1 : cpu_busreq_n;

  int checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference
  int m_req = 1, m_cnt = 0, m_phase = 0, m_fs = 1, m_int = 0, m_go = 0, m_drop = 0, m_addr = 0;

  function automatic int scramble(int row, int col);
    int l, a;
    l = row * 32 + col;
    a = l & ~32'h7E0;
    a = a | (((l >> 5) & 7) << 8) | (((l >> 8) & 7) << 5);
    return a;
  endfunction

  always @(posedge clk) begin
    int rel, sel;
    if (!rst_n) begin
      m_req <= 1; m_cnt <= 0; m_phase <= 0; m_fs <= 1; m_int <= 0;
      m_go <= 0; m_drop <= 0; m_addr <= 0;
    end else begin
      rel = (!line_sync_n || !cpu_iorq_n || mode == 2'b01 ||
             (mode == 2'b10 && !cpu_a14) || (mode == 2'b11 && m_phase == 1)) ? 1 : 0;
      sel = (!cpu_busack_n && m_req == 0) ? 1 : 0;
      m_req <= rel;
      if (m_cnt == SPLIT - 1) begin m_cnt <= 0; m_phase <= 1 - m_phase; end
      else m_cnt <= m_cnt + 1;
      m_fs <= frame_sync_n;
      if (m_fs == 1 && !frame_sync_n) m_int <= INTC;
      else if (!cpu_m1_n && !cpu_iorq_n) m_int <= 0;
      else if (m_int > 0) m_int <= m_int - 1;
      m_go   <= (vid_fetch && sel == 1) ? 1 : 0;
      m_drop <= (vid_fetch && sel == 0) ? 1 : 0;
      if (vid_fetch) m_addr <= scramble(vid_row, vid_col);
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({tag, " busreq"}, cpu_busreq_n, m_req);
    chk({tag, " int"}, cpu_int_n, (m_int == 0) ? 1 : 0);
    chk("R7 vid_sel", vid_sel, (!cpu_busack_n && m_req == 0) ? 1 : 0);
    chk("R8 go", vid_fetch_go, m_go);
    chk("R8 drop", vid_fetch_drop, m_drop);
    chk("R9 addr", vid_addr, m_addr);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lowc;
    tick(3);
    chk("R1 busreq in reset", cpu_busreq_n, 1);
    chk("R1 int in reset", cpu_int_n, 1);
    chk("R1 go in reset", vid_fetch_go, 0);
    rst_n = 1'b1;

    tag = "R3"; tick(3);
    chk("R3 mode0 requested", cpu_busreq_n, 0);
    tag = "R2"; line_sync_n = 1'b0; tick(1);
    chk("R2 line sync releases", cpu_busreq_n, 1);
    tick(3); line_sync_n = 1'b1; tick(2);
    chk("R2 request back after sync", cpu_busreq_n, 0);
    tag = "R3"; mode = 2'b01; tick(1);
    chk("R3 mode1 released", cpu_busreq_n, 1);
    tick(4);

    tag = "R4"; mode = 2'b10;
    for (int i = 0; i < 12; i++) begin cpu_a14 = i[1]; tick(1); end
    cpu_a14 = 1'b0; tick(1);
    chk("R4 rom fetch releases", cpu_busreq_n, 1);
    cpu_a14 = 1'b1; tick(1);
    chk("R4 ram fetch requests", cpu_busreq_n, 0);

    tag = "R5"; mode = 2'b11; tick(5 * SPLIT);

    tag = "R6"; mode = 2'b00; tick(3);
    cpu_iorq_n = 1'b0; tick(1);
    chk("R6 io strobe releases", cpu_busreq_n, 1);
    cpu_iorq_n = 1'b1; tick(3);

    tag = "R8";
    for (int i = 0; i < 8; i++) begin
      vid_row = 8'(1 << i); vid_col = 5'(i * 3 + 1); vid_fetch = 1'b1; tick(1);
      vid_fetch = 1'b0; tick(1);
    end
    vid_row = 8'd1; vid_col = 5'd0; vid_fetch = 1'b1; tick(1); vid_fetch = 1'b0;
    chk("R9 row1 col0 address", vid_addr, 256);
    chk("R8 granted slot served", vid_fetch_go, 1);
    vid_row = 8'd8; vid_fetch = 1'b1; tick(1); vid_fetch = 1'b0;
    chk("R9 row8 col0 address", vid_addr, 32);
    ack_hold = 1'b1; tick(2);
    vid_fetch = 1'b1; tick(1); vid_fetch = 1'b0;
    chk("R8 ungranted slot dropped", vid_fetch_drop, 1);
    ack_hold = 1'b0; tick(3);

    tag = "R10"; frame_sync_n = 1'b0; tick(1);
    lowc = 0;
    while (cpu_int_n == 1'b0 && lowc < 100) begin lowc++; tick(1); end
    chk("R10 pulse length with level held low", lowc, INTC);
    frame_sync_n = 1'b1; tick(3);

    tag = "R11"; frame_sync_n = 1'b0; tick(1); frame_sync_n = 1'b1; tick(4);
    cpu_m1_n = 1'b0; cpu_iorq_n = 1'b0; tick(1);
    cpu_m1_n = 1'b1; cpu_iorq_n = 1'b1;
    chk("R11 acknowledge ends pulse", cpu_int_n, 1);
    tick(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule